// File: doc/BRIEF.md
# Overload Monitor and Window Validator

This block sits behind the analog front end and the converter of a flow measurement channel. Each valid converter sample is turned into a magnitude and compared against a programmable trip level. An external overload flag from the analog side is treated the same way. Every overload episode is counted once. The block measures how many samples the episode spends in overload and how many it spends recovering. It also records which measurement context was active at the onset, for example a polarity reversal, comms activity or a burst.

Downstream demodulation and estimation integrate over windows marked by start and end pulses. At each window end the block reports two things. The first is whether the window was clean, meaning no overload sample and no unfinished recovery anywhere inside it. The second is the headroom left between the largest magnitude seen and full scale. Separately, the block timestamps every change of the front-end gain index. Event and gain-change counts saturate and are cleared by a register write strobe.

Top module: `overload_window_monitor`

## Requirements
- R1: A valid sample whose magnitude is at or above `tripLevel`, or any valid sample with `extOverload` high, sets `overloadActive` at the next clock edge. The magnitude of the most negative code is 2^(CODE_W-1).
- R2: Each overload episode adds one to `eventCount` at its onset. `lastContext` reports the `ctxTag` present on the onset sample.
- R3: An episode ends after `releaseCount` consecutive valid samples with magnitude below `releaseLevel` and `extOverload` low. A `releaseCount` of 0 acts as 1. A non-overload sample at or above `releaseLevel` restarts the run. An overload sample during recovery resumes the same episode without a new count.
- R4: When an episode ends, `eventDone` pulses for one cycle. At the same time `lastDuration` gives the episode's overload-level valid samples, and `lastRecovery` gives its other valid samples, including the final release sample. Both saturate.
- R5: `winEnd` pulses `winReady` and sets `winValid` to 1 only if, since the window started, no valid overload sample occurred and `overloadActive` was never high. The sample in the `winEnd` cycle counts toward this.
- R6: At `winEnd`, `winPeakMargin` = 2^(CODE_W-1) minus the largest valid-sample magnitude in the window. An empty window gives 2^(CODE_W-1).
- R7: `winStart` opens a new window that includes the sample of its own cycle. When `winStart` and `winEnd` fall in the same cycle, that cycle's sample closes the old window only, and the new window starts empty.
- R8: When `gainIndex` differs from its value in the previous cycle (0 after reset), `gainLogIndex` takes the new index. `gainLogTime` takes the cycle count since reset, and `gainChanges` increments.
- R9: `eventCount` and `gainChanges` stop at their maximum instead of wrapping. `clearCounters` zeroes both, and it wins over an increment in the same cycle.
- R10: With `sampleValid` low, `sampleCode` and `extOverload` have no effect.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Converter sample strobe |
| sampleCode | input | CODE_W | Two's complement converter code |
| extOverload | input | 1 | Overload flag from the analog side |
| ctxTag | input | CTX_W | Current measurement context |
| tripLevel | input | CODE_W | Overload magnitude threshold |
| releaseLevel | input | CODE_W | Quiet magnitude threshold |
| releaseCount | input | RUN_W | Consecutive quiet samples needed to release |
| winStart | input | 1 | Integration window opens |
| winEnd | input | 1 | Integration window closes |
| gainIndex | input | GAIN_W | Current front-end gain step |
| clearCounters | input | 1 | Register-write strobe clearing the counters |
| overloadActive | output | 1 | Episode in overload or recovery |
| eventCount | output | EVT_W | Saturating episode count |
| lastDuration | output | DUR_W | Overload samples of last episode |
| lastRecovery | output | DUR_W | Recovery samples of last episode |
| lastContext | output | CTX_W | Context at onset of last episode |
| eventDone | output | 1 | One-cycle pulse at episode end |
| winReady | output | 1 | One-cycle pulse with window result |
| winValid | output | 1 | Last window was clean |
| winPeakMargin | output | CODE_W | Headroom of last window |
| gainLogIndex | output | GAIN_W | Gain index at last change |
| gainLogTime | output | TS_W | Cycle stamp of last change |
| gainChanges | output | GCNT_W | Saturating gain-change count |

## Verification
Window closing and overload onset can meet in one cycle. The bench drives an overload-level sample in the very cycle of `winEnd` for an otherwise clean window and expects `winValid` low, while `overloadActive` rises at the same edge. The bench also puts `winStart` and `winEnd` in the same cycle. It then checks from the margins of the closing and the following window that the shared sample counted only toward the window that closed. In the same way, a counter clear is issued together with an overload onset, and the count must read zero.

// File: rtl/ovm_pkg.sv
package ovm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_OVER    = 2'd1,
    ST_RECOVER = 2'd2
  } ovmState_t;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic evStart;  // new episode begins on this sample
    logic evOver;   // overload-level sample inside an episode
    logic evRec;    // non-overload valid sample inside an episode
    logic evDone;   // episode released on this sample
    logic dirty;    // current cycle spoils the open window
  } ctlStrobes_t;

endpackage

// File: rtl/ovm_ctrl.sv
module ovm_ctrl
  import ovm_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int RUN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] magNow,
  input  logic              extOverload,
  input  logic [CODE_W-1:0] tripLevel,
  input  logic [CODE_W-1:0] releaseLevel,
  input  logic [RUN_W-1:0]  releaseCount,
  output ctlStrobes_t       strobes,
  output logic              overloadActive
);

  ovmState_t        state, stateNext;
  logic [RUN_W-1:0] runCnt, runNext;
  logic [RUN_W:0]   relNeed, runInc;
  logic             overCond, quiet;

  assign overCond = sampleValid && (extOverload || (magNow >= tripLevel));
  assign quiet    = sampleValid && !extOverload && (magNow < releaseLevel);
  assign relNeed  = (releaseCount == '0) ? {{RUN_W{1'b0}}, 1'b1} : {1'b0, releaseCount};
  assign runInc   = {1'b0, runCnt} + 1'b1;

  always_comb begin
    stateNext = state;
    runNext   = runCnt;
    strobes   = '0;
    strobes.dirty = overCond || (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (overCond) begin
          strobes.evStart = 1'b1;
          stateNext = ST_OVER;
          runNext = '0;
        end
      end
      ST_OVER, ST_RECOVER: begin
        if (overCond) begin
          strobes.evOver = 1'b1;
          runNext = '0;
          stateNext = ST_OVER;
        end else if (sampleValid) begin
          strobes.evRec = 1'b1;
          if (quiet) begin
            if (((state == ST_OVER) ? {{RUN_W{1'b0}}, 1'b1} : runInc) >= relNeed) begin
              strobes.evDone = 1'b1;
              stateNext = ST_IDLE;
              runNext = '0;
            end else begin
              runNext = (state == ST_OVER) ? {{(RUN_W-1){1'b0}}, 1'b1} : runInc[RUN_W-1:0];
              stateNext = ST_RECOVER;
            end
          end else begin
            runNext = '0;
            stateNext = ST_RECOVER;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      runCnt <= '0;
    end else begin
      state  <= stateNext;
      runCnt <= runNext;
    end
  end

  assign overloadActive = (state != ST_IDLE);

  AST_ENTER_ON_OVERLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && (extOverload || magNow >= tripLevel)) |=> overloadActive); // R1
  AST_HOLD_WITHOUT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (overloadActive && !sampleValid) |=> overloadActive); // R10
  AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.evDone |=> !overloadActive); // R3

endmodule

// File: rtl/ovm_datapath.sv
module ovm_datapath
  import ovm_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int CTX_W  = 2,
  parameter int GAIN_W = 3,
  parameter int EVT_W  = 4,
  parameter int DUR_W  = 8,
  parameter int TS_W   = 16,
  parameter int GCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] magNow,
  input  logic [CTX_W-1:0]  ctxTag,
  input  logic              winStart,
  input  logic              winEnd,
  input  logic [GAIN_W-1:0] gainIndex,
  input  logic              clearCounters,
  output logic [EVT_W-1:0]  eventCount,
  output logic [DUR_W-1:0]  lastDuration,
  output logic [DUR_W-1:0]  lastRecovery,
  output logic [CTX_W-1:0]  lastContext,
  output logic              eventDone,
  output logic              winReady,
  output logic              winValid,
  output logic [CODE_W-1:0] winPeakMargin,
  output logic [GAIN_W-1:0] gainLogIndex,
  output logic [TS_W-1:0]   gainLogTime,
  output logic [GCNT_W-1:0] gainChanges
);

  localparam logic [CODE_W-1:0] FULL_SCALE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [DUR_W-1:0]  DUR_MAX    = {DUR_W{1'b1}};
  localparam logic [EVT_W-1:0]  EVT_MAX    = {EVT_W{1'b1}};
  localparam logic [GCNT_W-1:0] GCNT_MAX   = {GCNT_W{1'b1}};

  logic [CODE_W-1:0] peakReg, magValid, peakNow;
  logic              dirtyReg, dirtyNow;
  logic [DUR_W-1:0]  durCnt, recCnt, recNext;
  logic [CTX_W-1:0]  ctxHeld;
  logic [GAIN_W-1:0] prevGain;
  logic [TS_W-1:0]   timeNow;
  logic              gainMoved;

  assign magValid  = sampleValid ? magNow : '0;
  assign peakNow   = (magValid > peakReg) ? magValid : peakReg;
  assign dirtyNow  = dirtyReg || strobes.dirty;
  assign gainMoved = (gainIndex != prevGain);
  assign recNext   = (strobes.evRec && recCnt != DUR_MAX) ? recCnt + 1'b1 : recCnt;

  // window accumulation and result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peakReg <= '0;
      dirtyReg <= 1'b0;
      winReady <= 1'b0;
      winValid <= 1'b0;
      winPeakMargin <= '0;
    end else begin
      winReady <= winEnd;
      if (winEnd) begin
        winValid <= !dirtyNow;
        winPeakMargin <= FULL_SCALE - peakNow;
      end
      if (winStart && winEnd) begin
        peakReg <= '0;
        dirtyReg <= 1'b0;
      end else if (winStart) begin
        peakReg <= magValid;
        dirtyReg <= strobes.dirty;
      end else begin
        peakReg <= peakNow;
        dirtyReg <= dirtyNow;
      end
    end
  end

  // episode bookkeeping
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eventCount <= '0;
      durCnt <= '0;
      recCnt <= '0;
      ctxHeld <= '0;
      lastDuration <= '0;
      lastRecovery <= '0;
      lastContext <= '0;
      eventDone <= 1'b0;
    end else begin
      eventDone <= strobes.evDone;
      if (clearCounters) eventCount <= '0;
      else if (strobes.evStart && eventCount != EVT_MAX) eventCount <= eventCount + 1'b1;
      if (strobes.evStart) begin
        durCnt <= {{(DUR_W-1){1'b0}}, 1'b1};
        recCnt <= '0;
        ctxHeld <= ctxTag;
      end else begin
        if (strobes.evOver && durCnt != DUR_MAX) durCnt <= durCnt + 1'b1;
        recCnt <= recNext;
      end
      if (strobes.evDone) begin
        lastDuration <= durCnt;
        lastRecovery <= recNext;
        lastContext <= ctxHeld;
      end
    end
  end

  // gain change log
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevGain <= '0;
      timeNow <= '0;
      gainLogIndex <= '0;
      gainLogTime <= '0;
      gainChanges <= '0;
    end else begin
      prevGain <= gainIndex;
      timeNow <= timeNow + 1'b1;
      if (gainMoved) begin
        gainLogIndex <= gainIndex;
        gainLogTime <= timeNow;
      end
      if (clearCounters) gainChanges <= '0;
      else if (gainMoved && gainChanges != GCNT_MAX) gainChanges <= gainChanges + 1'b1;
    end
  end

  AST_EVT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (eventCount == EVT_MAX && !clearCounters) |=> eventCount == EVT_MAX); // R9
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clearCounters |=> (eventCount == '0 && gainChanges == '0)); // R9
  AST_DIRTY_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (winEnd && dirtyReg) |=> !winValid); // R5
  AST_PEAK_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !winStart |=> peakReg >= $past(peakReg)); // R6
  AST_GAIN_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    gainMoved |=> gainLogIndex == $past(gainIndex)); // R8

endmodule

// File: rtl/overload_window_monitor.sv
module overload_window_monitor
  import ovm_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int CTX_W  = 2,
  parameter int GAIN_W = 3,
  parameter int EVT_W  = 4,
  parameter int DUR_W  = 8,
  parameter int RUN_W  = 8,
  parameter int TS_W   = 16,
  parameter int GCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic              extOverload,
  input  logic [CTX_W-1:0]  ctxTag,
  input  logic [CODE_W-1:0] tripLevel,
  input  logic [CODE_W-1:0] releaseLevel,
  input  logic [RUN_W-1:0]  releaseCount,
  input  logic              winStart,
  input  logic              winEnd,
  input  logic [GAIN_W-1:0] gainIndex,
  input  logic              clearCounters,
  output logic              overloadActive,
  output logic [EVT_W-1:0]  eventCount,
  output logic [DUR_W-1:0]  lastDuration,
  output logic [DUR_W-1:0]  lastRecovery,
  output logic [CTX_W-1:0]  lastContext,
  output logic              eventDone,
  output logic              winReady,
  output logic              winValid,
  output logic [CODE_W-1:0] winPeakMargin,
  output logic [GAIN_W-1:0] gainLogIndex,
  output logic [TS_W-1:0]   gainLogTime,
  output logic [GCNT_W-1:0] gainChanges
);

  logic [CODE_W-1:0] magNow;
  ctlStrobes_t       strobes;

  // unsigned magnitude; the most negative code maps to full scale
  assign magNow = sampleCode[CODE_W-1] ? (~sampleCode + 1'b1) : sampleCode;

  ovm_ctrl #(.CODE_W(CODE_W), .RUN_W(RUN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .magNow(magNow),
    .extOverload(extOverload), .tripLevel(tripLevel), .releaseLevel(releaseLevel),
    .releaseCount(releaseCount), .strobes(strobes), .overloadActive(overloadActive)
  );

  ovm_datapath #(
    .CODE_W(CODE_W), .CTX_W(CTX_W), .GAIN_W(GAIN_W), .EVT_W(EVT_W),
    .DUR_W(DUR_W), .TS_W(TS_W), .GCNT_W(GCNT_W)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .sampleValid(sampleValid),
    .magNow(magNow), .ctxTag(ctxTag), .winStart(winStart), .winEnd(winEnd),
    .gainIndex(gainIndex), .clearCounters(clearCounters),
    .eventCount(eventCount), .lastDuration(lastDuration), .lastRecovery(lastRecovery),
    .lastContext(lastContext), .eventDone(eventDone), .winReady(winReady),
    .winValid(winValid), .winPeakMargin(winPeakMargin), .gainLogIndex(gainLogIndex),
    .gainLogTime(gainLogTime), .gainChanges(gainChanges)
  );

endmodule

// File: tb/tb_overload_window_monitor.sv
`timescale 1ns/1ps
module tb_overload_window_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleCode = '0;
  logic        extOverload = 1'b0;
  logic [1:0]  ctxTag = '0;
  logic [15:0] tripLevel = 16'd1000;
  logic [15:0] releaseLevel = 16'd500;
  logic [7:0]  releaseCount = 8'd3;
  logic        winStart = 1'b0;
  logic        winEnd = 1'b0;
  logic [2:0]  gainIndex = '0;
  logic        clearCounters = 1'b0;
  logic        overloadActive, eventDone, winReady, winValid;
  logic [3:0]  eventCount, gainChanges;
  logic [7:0]  lastDuration, lastRecovery;
  logic [1:0]  lastContext;
  logic [15:0] winPeakMargin, gainLogTime;
  logic [2:0]  gainLogIndex;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  overload_window_monitor dut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleCode(sampleCode),
    .extOverload(extOverload), .ctxTag(ctxTag), .tripLevel(tripLevel),
    .releaseLevel(releaseLevel), .releaseCount(releaseCount), .winStart(winStart),
    .winEnd(winEnd), .gainIndex(gainIndex), .clearCounters(clearCounters),
    .overloadActive(overloadActive), .eventCount(eventCount), .lastDuration(lastDuration),
    .lastRecovery(lastRecovery), .lastContext(lastContext), .eventDone(eventDone),
    .winReady(winReady), .winValid(winValid), .winPeakMargin(winPeakMargin),
    .gainLogIndex(gainLogIndex), .gainLogTime(gainLogTime), .gainChanges(gainChanges)
  );

  typedef struct packed {
    logic        v;
    logic [15:0] code;
    logic        ext;
    logic [1:0]  ctx;
    logic        ws;
    logic        we;
    logic        act;
    logic        done;
    logic        rdy;
    logic        vld;
    logic [7:0]  dur;
    logic [7:0]  rec;
    logic [1:0]  ectx;
  } vec_t;

  // trip 1000, release 500, three quiet samples to release
  localparam vec_t VEC [19] = '{
    '{1'b1, 16'd100,   1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd200,   1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd300,   1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd1000,  1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'hFB50,  1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd600,   1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd400,   1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b0, 16'd5000,  1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'hFF9C,  1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd700,   1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd0,     1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd0,     1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd0,     1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2, 8'd7, 2'd1},
    '{1'b1, 16'd0,     1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd0,     1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd0,     1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd0,     1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 2'd0},
    '{1'b1, 16'd0,     1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 8'd3, 2'd2},
    '{1'b1, 16'd50,    1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // present one cycle of inputs, then sample just after the edge
  task automatic apply(input logic v, input logic [15:0] code, input logic ext,
                       input logic [1:0] ctx, input logic ws, input logic we);
    sampleValid = v; sampleCode = code; extOverload = ext; ctxTag = ctx;
    winStart = ws; winEnd = we;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got 1 expected 0");
      summary();
    end
  end

  initial begin
    logic [15:0] t0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 overloadActive", overloadActive, 0);
    chk("R11 eventCount", eventCount, 0);
    chk("R11 winValid", winValid, 0);
    chk("R11 winPeakMargin", winPeakMargin, 0);
    chk("R11 gainChanges", gainChanges, 0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R10
    foreach (VEC[i]) begin
      apply(VEC[i].v, VEC[i].code, VEC[i].ext, VEC[i].ctx, VEC[i].ws, VEC[i].we);
      chk($sformatf("R1/R3/R10 row %0d overloadActive", i), overloadActive, VEC[i].act);
      chk($sformatf("R4 row %0d eventDone", i), eventDone, VEC[i].done);
      chk($sformatf("R5 row %0d winReady", i), winReady, VEC[i].rdy);
      if (VEC[i].rdy) chk($sformatf("R5 row %0d winValid", i), winValid, VEC[i].vld);
      if (VEC[i].done) begin
        chk($sformatf("R4 row %0d lastDuration", i), lastDuration, VEC[i].dur);
        chk($sformatf("R4 row %0d lastRecovery", i), lastRecovery, VEC[i].rec);
        chk($sformatf("R2 row %0d lastContext", i), lastContext, VEC[i].ectx);
      end
      if (i == 2) chk("R6 clean window margin", winPeakMargin, 32768 - 300);
    end
    chk("R2 eventCount after table", eventCount, 2);

    // R7: start and end together; shared sample closes old window only
    apply(1, 16'd10, 0, 0, 1, 0);
    apply(1, 16'd20, 0, 0, 1, 1);
    chk("R7 closing window valid", winValid, 1);
    chk("R7 closing window margin", winPeakMargin, 32768 - 20);
    apply(1, 16'd5, 0, 0, 0, 1);
    chk("R7 next window margin", winPeakMargin, 32768 - 5);

    // R5: overload onset in the window-end cycle
    apply(1, 16'd10, 0, 0, 1, 0);
    apply(1, 16'd2000, 0, 3, 0, 1);
    chk("R5 onset at window end invalid", winValid, 0);
    chk("R1 onset at window end active", overloadActive, 1);
    repeat (3) apply(1, 16'd0, 0, 0, 0, 0);
    chk("R3 released", overloadActive, 0);

    // R6: full-scale negative code leaves no headroom
    apply(1, 16'd0, 0, 0, 1, 0);
    apply(1, 16'h8000, 0, 0, 0, 1);
    chk("R6 full scale margin", winPeakMargin, 0);
    chk("R1 most negative code trips", overloadActive, 1);
    repeat (3) apply(1, 16'd0, 0, 0, 0, 0);
    // R6 empty window
    apply(0, 16'd0, 0, 0, 1, 0);
    apply(0, 16'd0, 0, 0, 0, 1);
    chk("R6 empty window margin", winPeakMargin, 32768);
    chk("R5 empty window valid", winValid, 1);

    // R8 gain log
    gainIndex = 3'd3;
    apply(1, 16'd0, 0, 0, 0, 0);
    t0 = gainLogTime;
    chk("R8 gain index", gainLogIndex, 3);
    chk("R8 gain changes", gainChanges, 1);
    repeat (5) apply(1, 16'd0, 0, 0, 0, 0);
    chk("R8 no change no count", gainChanges, 1);
    gainIndex = 3'd5;
    apply(1, 16'd0, 0, 0, 0, 0);
    chk("R8 stamp spacing", gainLogTime - t0, 6);
    chk("R8 gain index second", gainLogIndex, 5);

    // R9 saturation, R3 release count zero acts as one
    releaseCount = 8'd0;
    for (int k = 0; k < 16; k++) begin
      apply(1, 16'd2000, 0, 0, 0, 0);
      apply(1, 16'd0, 0, 0, 0, 0);
      if (k == 0) chk("R3 zero release count", overloadActive, 0);
    end
    chk("R9 event count saturates", eventCount, 15);

    // R9 clear wins over simultaneous onset
    clearCounters = 1'b1;
    apply(1, 16'd2000, 0, 0, 0, 0);
    clearCounters = 1'b0;
    chk("R9 clear event count", eventCount, 0);
    chk("R9 clear gain changes", gainChanges, 0);
    apply(1, 16'd0, 0, 0, 0, 0);
    apply(1, 16'd2000, 0, 0, 0, 0);
    chk("R9 count after clear", eventCount, 1);
    apply(1, 16'd0, 0, 0, 0, 0);

    summary();
  end

endmodule